// File: doc/BRIEF.md
# Device Life-Cycle State Decoder

This block turns the content of fuse word 0 into a two-bit device life-cycle mode. From that mode it derives the host access rights and the debug enables. The device moves one way through three ordinary modes: open, secured and closed. A fourth, terminal mode marks a compromised word 0. In that mode the block withdraws every access to the stored secrets and turns off all debug.

The mode is evaluated afresh when the fuse controller signals the end of its reset load. It is evaluated again each time a software-triggered read of word 0 completes. An evaluation driven by a read can only move the mode forward. Each evaluation also refreshes the permission outputs for three register regions: control, lower shadows and upper shadows. The debug-enable vector is refreshed at the same time. Every output is registered and changes on the clock edge that samples the strobe.

Top module: `lcs_decoder`

## Requirements
- R1: While `rst` is high and until the first load strobe, `mode` is 2'b11 (invalid), `perm_rd` is 3'b001, `perm_wr` is 3'b000 and `dbg_en` is all zeros.
- R2: On an edge where `load_done` is 1, the block loads the mode decoded from `word` and `word_bad`, and that mode becomes visible after the edge. A clean word with bit 6 set decodes to 2'b10 (closed), whatever the value of bit 5. A clean word with bit 6 clear and bit 5 set decodes to 2'b01 (secured). A clean word with both bits clear decodes to 2'b00 (open). The loaded value replaces the previous mode even when it is lower.
- R3: When `word_bad` is 1, the decoded mode is 2'b11 (invalid) regardless of the bits of `word`.
- R4: When `rd_done` is 1 and `rd_addr` is 0 on an edge where `load_done` is 0, the mode is re-evaluated. A read completion at any other address changes no output.
- R5: A re-evaluation driven by a read never lowers the mode. The new mode is the larger of the current mode and the decoded mode. As a result, invalid stays invalid until the next load strobe, and a read before the first load leaves the mode invalid.
- R6: The permission vectors use bit 0 for control, bit 1 for lower shadows and bit 2 for upper shadows, with 1 meaning allowed. The values are: open rd 111 / wr 111, secured rd 111 / wr 011, closed rd 011 / wr 011, invalid rd 001 / wr 000.
- R7: `dbg_en` is all ones when open, equals `DBG_SECURED_MASK` (default 4'b0011) when secured, and is all zeros when closed or invalid.
- R8: On an edge with no load strobe and no read completion at address 0, `mode`, `perm_rd`, `perm_wr` and `dbg_en` all hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_done | input | 1 | End-of-reset-load strobe; `word` holds word 0 |
| rd_done | input | 1 | Software read completion strobe |
| rd_addr | input | ADDR_W | Fuse word index of the completed read |
| word | input | WORD_W | Value of word 0 with the strobe |
| word_bad | input | 1 | Integrity failure flag for word 0 |
| mode | output | 2 | Life-cycle mode: 00 open, 01 secured, 10 closed, 11 invalid |
| perm_rd | output | 3 | Read permission per region (0 control, 1 lower, 2 upper) |
| perm_wr | output | 3 | Write permission per region |
| dbg_en | output | DBG_W | Debug enable vector |

## Verification
The assertions watch every cycle for four relations. The invalid mode must always show control-only read access with no write and no debug. The closed mode must always hide the upper shadows and clear debug. Without a load strobe the mode must never drop. Without a relevant strobe every output must hold. Some behaviour cannot be stated as a property over the ports, and the directed scenarios cover it. This covers the decoding of particular word patterns, the priority of the bad flag and of bit 6, a load that lowers the mode, a read at a different address having no effect, and a read before the first load.

// File: rtl/lcs_pkg.sv
package lcs_pkg;

  typedef enum logic [1:0] {
    LC_OPEN    = 2'b00,
    LC_SECURED = 2'b01,
    LC_CLOSED  = 2'b10,
    LC_INVALID = 2'b11
  } lc_mode_e;

  localparam int unsigned N_REGION   = 3;
  localparam int unsigned REG_CTRL   = 0;
  localparam int unsigned REG_LOWER  = 1;
  localparam int unsigned REG_UPPER  = 2;

  // Read rights for one region in one mode
  function automatic logic rd_allow(lc_mode_e m, int unsigned region);
    case (m)
      LC_OPEN, LC_SECURED: rd_allow = 1'b1;
      LC_CLOSED:           rd_allow = (region != REG_UPPER);
      default:             rd_allow = (region == REG_CTRL);
    endcase
  endfunction

  // Write rights for one region in one mode
  function automatic logic wr_allow(lc_mode_e m, int unsigned region);
    case (m)
      LC_OPEN:               wr_allow = 1'b1;
      LC_SECURED, LC_CLOSED: wr_allow = (region != REG_UPPER);
      default:               wr_allow = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/lcs_word_decode.sv
module lcs_word_decode
  import lcs_pkg::*;
#(
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned CLOSE_BIT  = 6,
  parameter int unsigned SECURE_BIT = 5
) (
  input  logic [WORD_W-1:0] word,
  input  logic              word_bad,
  output lc_mode_e          cand
);

  logic unused_word_bits;
  assign unused_word_bits = ^word;

  always_comb begin
    if (word_bad)              cand = LC_INVALID;
    else if (word[CLOSE_BIT])  cand = LC_CLOSED;
    else if (word[SECURE_BIT]) cand = LC_SECURED;
    else                       cand = LC_OPEN;
  end

endmodule

// File: rtl/lcs_mode_track.sv
module lcs_mode_track
  import lcs_pkg::*;
#(
  parameter int unsigned ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_done,
  input  logic              rd_done,
  input  logic [ADDR_W-1:0] rd_addr,
  input  lc_mode_e          cand,
  output lc_mode_e          mode_q,
  output lc_mode_e          mode_nxt,
  output logic              update
);

  logic rd_word0;
  assign rd_word0 = rd_done && (rd_addr == '0);
  assign update   = load_done || rd_word0;

  always_comb begin
    if (load_done)       mode_nxt = cand;
    else if (rd_word0)   mode_nxt = (cand > mode_q) ? cand : mode_q;
    else                 mode_nxt = mode_q;
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= LC_INVALID;
    else     mode_q <= mode_nxt;
  end

endmodule

// File: rtl/lcs_access_map.sv
module lcs_access_map
  import lcs_pkg::*;
#(
  parameter int unsigned DBG_W            = 4,
  parameter logic [DBG_W-1:0] DBG_SECURED_MASK = 4'b0011
) (
  input  lc_mode_e             m,
  output logic [N_REGION-1:0]  rd,
  output logic [N_REGION-1:0]  wr,
  output logic [DBG_W-1:0]     dbg
);

  for (genvar r = 0; r < N_REGION; r++) begin : g_region
    assign rd[r] = rd_allow(m, r);
    assign wr[r] = wr_allow(m, r);
  end

  always_comb begin
    case (m)
      LC_OPEN:    dbg = '1;
      LC_SECURED: dbg = DBG_SECURED_MASK;
      default:    dbg = '0;
    endcase
  end

endmodule

// File: rtl/lcs_decoder.sv
module lcs_decoder
  import lcs_pkg::*;
#(
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned ADDR_W     = 7,
  parameter int unsigned CLOSE_BIT  = 6,
  parameter int unsigned SECURE_BIT = 5,
  parameter int unsigned DBG_W      = 4,
  parameter logic [DBG_W-1:0] DBG_SECURED_MASK = 4'b0011
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_done,
  input  logic              rd_done,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [WORD_W-1:0] word,
  input  logic              word_bad,
  output logic [1:0]        mode,
  output logic [2:0]        perm_rd,
  output logic [2:0]        perm_wr,
  output logic [DBG_W-1:0]  dbg_en
);

  lc_mode_e            cand;
  lc_mode_e            mode_q;
  lc_mode_e            mode_nxt;
  logic                update;
  logic [N_REGION-1:0] rd_nxt;
  logic [N_REGION-1:0] wr_nxt;
  logic [DBG_W-1:0]    dbg_nxt;

  lcs_word_decode #(
    .WORD_W(WORD_W), .CLOSE_BIT(CLOSE_BIT), .SECURE_BIT(SECURE_BIT)
  ) u_dec (
    .word(word), .word_bad(word_bad), .cand(cand)
  );

  lcs_mode_track #(.ADDR_W(ADDR_W)) u_track (
    .clk(clk), .rst(rst), .load_done(load_done), .rd_done(rd_done),
    .rd_addr(rd_addr), .cand(cand), .mode_q(mode_q),
    .mode_nxt(mode_nxt), .update(update)
  );

  lcs_access_map #(.DBG_W(DBG_W), .DBG_SECURED_MASK(DBG_SECURED_MASK)) u_map (
    .m(mode_nxt), .rd(rd_nxt), .wr(wr_nxt), .dbg(dbg_nxt)
  );

  assign mode = mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      perm_rd <= 3'b001;
      perm_wr <= 3'b000;
      dbg_en  <= '0;
    end else if (update) begin
      perm_rd <= rd_nxt;
      perm_wr <= wr_nxt;
      dbg_en  <= dbg_nxt;
    end
  end

endmodule

// File: rtl/lcs_decoder_chk.sv
module lcs_decoder_chk #(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DBG_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              load_done,
  input logic              rd_done,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [1:0]        mode,
  input logic [2:0]        perm_rd,
  input logic [2:0]        perm_wr,
  input logic [DBG_W-1:0]  dbg_en
);

  // R1
  reset_invalid_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mode == 2'b11 && dbg_en == '0));

  // R3
  invalid_lockout_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b11) |-> (perm_rd == 3'b001 && perm_wr == 3'b000 && dbg_en == '0));

  // R6
  closed_upper_hidden_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10) |-> (!perm_rd[2] && !perm_wr[2] && dbg_en == '0));

  // R5
  no_regress_chk: assert property (@(posedge clk) disable iff (rst)
    !load_done |=> (mode >= $past(mode)));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_done && !(rd_done && rd_addr == '0)) |=>
      ($stable(mode) && $stable(perm_rd) && $stable(perm_wr) && $stable(dbg_en)));

endmodule

bind lcs_decoder lcs_decoder_chk #(.ADDR_W(ADDR_W), .DBG_W(DBG_W)) u_chk (
  .clk(clk), .rst(rst), .load_done(load_done), .rd_done(rd_done),
  .rd_addr(rd_addr), .mode(mode), .perm_rd(perm_rd), .perm_wr(perm_wr),
  .dbg_en(dbg_en)
);

// File: tb/lcs_decoder_bench.sv
module lcs_decoder_bench;

  localparam int WORD_W = 32;
  localparam int ADDR_W = 7;
  localparam int DBG_W  = 4;

  logic              clk = 0;
  logic              rst = 1;
  logic              load_done = 0;
  logic              rd_done = 0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [WORD_W-1:0] word = '0;
  logic              word_bad = 0;
  logic [1:0]        mode;
  logic [2:0]        perm_rd;
  logic [2:0]        perm_wr;
  logic [DBG_W-1:0]  dbg_en;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  lcs_decoder u_lcs_decoder (
    .clk(clk), .rst(rst), .load_done(load_done), .rd_done(rd_done),
    .rd_addr(rd_addr), .word(word), .word_bad(word_bad), .mode(mode),
    .perm_rd(perm_rd), .perm_wr(perm_wr), .dbg_en(dbg_en)
  );

  // Expected outputs from the requirement tables (R6, R7)
  function automatic logic [2:0] exp_rd(logic [1:0] m);
    case (m)
      2'b00, 2'b01: exp_rd = 3'b111;
      2'b10:        exp_rd = 3'b011;
      default:      exp_rd = 3'b001;
    endcase
  endfunction

  function automatic logic [2:0] exp_wr(logic [1:0] m);
    case (m)
      2'b00:        exp_wr = 3'b111;
      2'b01, 2'b10: exp_wr = 3'b011;
      default:      exp_wr = 3'b000;
    endcase
  endfunction

  function automatic logic [DBG_W-1:0] exp_dbg(logic [1:0] m);
    case (m)
      2'b00:   exp_dbg = 4'b1111;
      2'b01:   exp_dbg = 4'b0011;
      default: exp_dbg = 4'b0000;
    endcase
  endfunction

  task automatic check(string req, logic [1:0] m_exp);
    n_checks++;
    if (mode !== m_exp || perm_rd !== exp_rd(m_exp) ||
        perm_wr !== exp_wr(m_exp) || dbg_en !== exp_dbg(m_exp)) begin
      n_fail++;
      $display("FAIL %s: mode=%b rd=%b wr=%b dbg=%b expected mode=%b rd=%b wr=%b dbg=%b",
               req, mode, perm_rd, perm_wr, dbg_en,
               m_exp, exp_rd(m_exp), exp_wr(m_exp), exp_dbg(m_exp));
    end
  endtask

  // One strobe cycle: drive at negedge, sample just after the next posedge
  task automatic pulse(bit ld, bit rd, logic [ADDR_W-1:0] a,
                       logic [WORD_W-1:0] w, bit bad);
    @(negedge clk);
    load_done = ld; rd_done = rd; rd_addr = a; word = w; word_bad = bad;
    @(posedge clk); #1;
    load_done = 0; rd_done = 0; rd_addr = '0; word = '0; word_bad = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    @(posedge clk); @(posedge clk); #1;
    check("R1 during reset", 2'b11);
    @(negedge clk); rst = 0;
    @(posedge clk); #1;
    check("R1 after reset", 2'b11);
  endtask

  task automatic t_pre_load_read();
    do_reset();
    pulse(0, 1, 0, 32'h0, 0);
    check("R5 read before load stays invalid", 2'b11);
  endtask

  task automatic t_progression();
    do_reset();
    pulse(1, 0, 0, 32'h0, 0);
    check("R2 load open", 2'b00);
    pulse(0, 1, 7'd5, 32'h40, 0);
    check("R4 read other address ignored", 2'b00);
    pulse(0, 0, 0, 32'h40, 0);
    check("R8 idle hold", 2'b00);
    pulse(0, 1, 0, 32'h20, 0);
    check("R4 read word0 secured", 2'b01);
    pulse(0, 1, 0, 32'h40, 0);
    check("R6 R7 read word0 closed", 2'b10);
    pulse(0, 1, 0, 32'h0, 0);
    check("R5 no regress on read", 2'b10);
  endtask

  task automatic t_invalid();
    do_reset();
    pulse(1, 0, 0, 32'h20, 0);
    check("R2 load secured", 2'b01);
    pulse(0, 1, 0, 32'h0, 1);
    check("R3 bad flag on read", 2'b11);
    pulse(0, 1, 0, 32'h20, 0);
    check("R5 invalid is terminal on read", 2'b11);
    pulse(1, 0, 0, 32'h20, 0);
    check("R2 load lowers mode", 2'b01);
    pulse(1, 0, 0, 32'h60, 1);
    check("R3 bad overrides bits on load", 2'b11);
  endtask

  task automatic t_bit_priority();
    do_reset();
    pulse(1, 0, 0, 32'h60, 0);
    check("R2 bit6 beats bit5", 2'b10);
    pulse(1, 0, 0, 32'hFFFF_FF9F, 0);
    check("R2 other bits ignored", 2'b00);
  endtask

  initial begin
    t_pre_load_read();
    t_progression();
    t_invalid();
    t_bit_priority();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule